// File: doc/BRIEF.md
# Programmable Interrupt Condition Router

This block gathers interrupt conditions from four doorbell banks of sixteen conditions each. It latches every condition into a sticky pending bit and steers each pending condition to one of eight level-sensitive interrupt outputs. Each condition has its own 4-bit destination code, so several conditions can share an output while others stay silent. Software reads the pending bits, clears them with a write-1-to-clear register and programs the destination codes, all through one flat register port. The port has an address, a write strobe, write data and combinational read data.

Each bank occupies a 16-byte window starting at base = 0x280 + 0x10 × bank. The window holds two routing words at base+0x0 and base+0x4, the clear register at base+0x8 and the pending status at base+0xC. Interrupt output k is a registered level. It is high while at least one pending condition carries destination code k.

Top module: `irq_router`

## Requirements
- R1: After reset every pending bit is 0, every destination code is 0000b, every interrupt output is low, and every status and routing register reads 0.
- R2: A high level on `evt_i[16*b+n]` during a clock edge sets pending bit n of bank b. The status register at base+0xC returns bank b's pending bits in bits [15:0], with bit n for condition n, and zeros above them.
- R3: Writing the clear register at base+0x8 clears every pending bit of that bank whose write-data bit is 1. Bits written as 0 are left unchanged. The clear register always reads 0.
- R4: When an event and a clear hit the same pending bit at the same edge, the bit ends up set.
- R5: The word at base+0x0 holds the codes for conditions 0–7 and the word at base+0x4 holds those for conditions 8–15. Condition n's code sits in bits [4(n mod 8)+3 : 4(n mod 8)]. Written words read back unchanged.
- R6: A code k in 0000b–0111b drives `irq_o[k]` high while the condition is pending. The output follows a change in pending state or routing one clock edge later.
- R7: Code 1111b disables the condition. It drives no output, but its pending bit still sets and reads back.
- R8: Codes 1000b–1110b behave exactly like 1111b.
- R9: Several conditions may carry the same code. Their output stays high until the last of them is cleared.
- R10: Writes to a status register or to an unmapped address change no state. Reads of unmapped or non-word-aligned addresses (address bits [1:0] not 00b) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 64 | Condition event inputs, bank b bit n at index 16*b+n |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 8 | Registered interrupt destination levels |

## Verification
The bench builds the block with its default parameters: four banks of sixteen conditions, eight destinations, 32-bit data and a window base of 0x280. That makes every legal destination code, all seven reserved codes, the disable code and all four bank windows reachable with directed writes. It also makes both halves of a bank's routing pair reachable, so the field-position rule is checked on both the low and the high routing word. A bench-side model of pending bits and codes predicts each output level one edge after each change, and covers the event-versus-clear collision and a reroute of a condition that is already pending.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int CODE_W = 4;

  // Word slot inside a bank's 16-byte window
  typedef enum logic [1:0] {
    SLOT_RT_LO = 2'd0,
    SLOT_RT_HI = 2'd1,
    SLOT_CLR   = 2'd2,
    SLOT_STAT  = 2'd3
  } slot_e;

  typedef struct packed {
    logic       hit;
    logic [7:0] bank;
    slot_e      slot;
  } dec_t;

  // Split a byte address into bank and slot; hit only for aligned, in-range words
  function automatic dec_t decode_addr(input logic [15:0] addr,
                                       input logic [15:0] base,
                                       input logic [11:0] nbanks);
    dec_t        d;
    logic [15:0] off;
    off    = addr - base;
    d.hit  = (addr >= base) && (off[15:4] < nbanks) && (off[1:0] == 2'b00);
    d.bank = off[11:4];
    d.slot = slot_e'(off[3:2]);
    return d;
  endfunction

  // A code selects destination k only when it names a real destination
  function automatic logic code_selects(input logic [CODE_W-1:0] code,
                                        input logic [CODE_W-1:0] k,
                                        input logic [CODE_W-1:0] ndest);
    return (code < ndest) && (code == k);
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend
);

  // Clear first, then set: an event in the same cycle keeps the bit pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | evt;
  end

endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank #(
  parameter int W      = 16,
  parameter int CODE_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_slot,
  input  logic [DATA_W-1:0]   wdata,
  output logic [W*CODE_W-1:0] codes
);

  localparam int NREG = (W * CODE_W) / DATA_W;

  for (genvar r = 0; r < NREG; r++) begin : g_word
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word_q <= '0;
      else if (wr_en && (wr_slot == 1'(r))) word_q <= wdata;
    end

    assign codes[r*DATA_W +: DATA_W] = word_q;
  end

endmodule

// File: rtl/irq_dest_merge.sv
module irq_dest_merge
  import irq_route_pkg::*;
#(
  parameter int NCOND = 64,
  parameter int NDEST = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCOND-1:0]        pend,
  input  logic [NCOND*CODE_W-1:0] codes,
  output logic [NDEST-1:0]        irq_q
);

  logic [NDEST-1:0] dest_hit;

  for (genvar k = 0; k < NDEST; k++) begin : g_dest
    always_comb begin
      dest_hit[k] = 1'b0;
      for (int i = 0; i < NCOND; i++) begin
        if (pend[i] && code_selects(codes[i*CODE_W +: CODE_W],
                                    CODE_W'(k), CODE_W'(NDEST)))
          dest_hit[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= dest_hit;
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
#(
  parameter int              NUM_BANKS = 4,
  parameter int              BANK_BITS = 16,
  parameter int              NUM_DEST  = 8,
  parameter int              ADDR_W    = 12,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h280
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_BANKS*BANK_BITS-1:0] evt_i,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic                           reg_we,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  output logic [NUM_DEST-1:0]            irq_o
);

  localparam int NCOND  = NUM_BANKS * BANK_BITS;
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int RT_W   = BANK_BITS * CODE_W;
  localparam int NREG   = RT_W / DATA_W;

  // Named internal events for the checker
  dec_t                    dec;
  logic [NCOND-1:0]        pend_all;
  logic [NCOND-1:0]        clr_mask;
  logic [NCOND*CODE_W-1:0] route_flat;
  logic                    clr_sel;

  logic [BANK_BITS-1:0] pend_bank [NUM_BANKS];
  logic [DATA_W-1:0]    rt_word   [NUM_BANKS][NREG];

  assign dec     = decode_addr(16'(reg_addr), 16'(BASE_ADDR), 12'(NUM_BANKS));
  assign clr_sel = dec.hit && (dec.slot == SLOT_CLR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    logic rt_we;

    assign sel   = dec.hit && (dec.bank == 8'(b));
    assign rt_we = reg_we && sel &&
                   ((dec.slot == SLOT_RT_LO) || (dec.slot == SLOT_RT_HI));
    assign clr_mask[b*BANK_BITS +: BANK_BITS] =
      (reg_we && sel && (dec.slot == SLOT_CLR)) ? reg_wdata[BANK_BITS-1:0] : '0;

    irq_pend_bank #(.W(BANK_BITS)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i[b*BANK_BITS +: BANK_BITS]),
      .clr_mask (clr_mask[b*BANK_BITS +: BANK_BITS]),
      .pend     (pend_all[b*BANK_BITS +: BANK_BITS])
    );

    irq_route_bank #(.W(BANK_BITS), .CODE_W(CODE_W), .DATA_W(DATA_W)) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rt_we),
      .wr_slot (dec.slot[0]),
      .wdata   (reg_wdata),
      .codes   (route_flat[b*RT_W +: RT_W])
    );

    assign pend_bank[b] = pend_all[b*BANK_BITS +: BANK_BITS];
    for (genvar r = 0; r < NREG; r++) begin : g_rw
      assign rt_word[b][r] = route_flat[b*RT_W + r*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (dec.hit) begin
      unique case (dec.slot)
        SLOT_RT_LO, SLOT_RT_HI:
          reg_rdata = rt_word[dec.bank[BANK_W-1:0]][dec.slot[0]];
        SLOT_STAT:
          reg_rdata = {{(DATA_W-BANK_BITS){1'b0}}, pend_bank[dec.bank[BANK_W-1:0]]};
        default:
          reg_rdata = '0;
      endcase
    end
  end

  irq_dest_merge #(.NCOND(NCOND), .NDEST(NUM_DEST)) u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_all),
    .codes (route_flat),
    .irq_q (irq_o)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NCOND  = 64,
  parameter int NDEST  = 8,
  parameter int CW     = 4,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCOND-1:0]    evt_i,
  input logic [NCOND-1:0]    clr_mask,
  input logic [NCOND-1:0]    pend_all,
  input logic [NCOND*CW-1:0] route_flat,
  input logic [NDEST-1:0]    irq_o,
  input logic                clr_sel,
  input logic [DATA_W-1:0]   reg_rdata
);

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_all & $past(evt_i)) == $past(evt_i)));

  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_all & $past(clr_mask & ~evt_i)) == '0));

  a_r3_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sel |-> (reg_rdata == '0));

  a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & clr_mask)) |=>
      ((pend_all & $past(evt_i & clr_mask)) == $past(evt_i & clr_mask)));

  a_r10_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_all & ~$past(pend_all) & ~$past(evt_i)) == '0));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all == '0) |=> (irq_o == '0));

  a_r6_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pend_all) && $stable(route_flat)) |=> $stable(irq_o));

endmodule

bind irq_router irq_router_chk #(
  .NCOND  (NCOND),
  .NDEST  (NUM_DEST),
  .CW     (irq_route_pkg::CODE_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .clr_mask   (clr_mask),
  .pend_all   (pend_all),
  .route_flat (route_flat),
  .irq_o      (irq_o),
  .clr_sel    (clr_sel),
  .reg_rdata  (reg_rdata)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;
  localparam int NB = 4, BB = 16, ND = 8, NC = NB * BB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] evt = '0;
  logic [11:0]   addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [ND-1:0] irq;

  int vectors = 0;
  int fails = 0;

  logic [NC-1:0] m_pend = '0;
  logic [3:0]    m_code [NC];

  always #5 clk = ~clk;

  irq_router u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [11:0] base_of(input int b);
    return 12'(12'h280 + 16 * b);
  endfunction

  // Independent restatement: a code below 8 names an output, anything else none
  function automatic logic [ND-1:0] model_irq();
    logic [ND-1:0] r = '0;
    for (int i = 0; i < NC; i++)
      if (m_pend[i] && (m_code[i] <= 4'd7)) r[m_code[i][2:0]] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [NC-1:0] m);
    evt = m;
    tick();
    evt = '0;
    m_pend |= m;
  endtask

  task automatic clear(input int b, input logic [15:0] mask);
    wr(base_of(b) + 12'h8, {16'h0, mask});
    m_pend[b*BB +: BB] = m_pend[b*BB +: BB] & ~mask;
  endtask

  task automatic set_code(input int c, input logic [3:0] code);
    int b = c / BB;
    int h = (c % BB) / 8;
    logic [31:0] w;
    m_code[c] = code;
    for (int j = 0; j < 8; j++) w[4*j +: 4] = m_code[b*BB + h*8 + j];
    wr(base_of(b) + 12'(4 * h), w);
  endtask

  task automatic check_irq(input string req);
    check(req, 32'(irq), 32'(model_irq()));
  endtask

  task automatic check_stat(input string req, input int b);
    logic [31:0] d;
    rd(base_of(b) + 12'hC, d);
    check(req, d, {16'h0, m_pend[b*BB +: BB]});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 outputs", 32'(irq), 32'h0);
    for (int b = 0; b < NB; b++) begin
      check_stat("R1 status", b);
      rd(base_of(b), d);        check("R1 route lo", d, 32'h0);
      rd(base_of(b) + 12'h4, d); check("R1 route hi", d, 32'h0);
    end
  endtask

  task automatic t_default_route();
    pulse(NC'(1) << (2*BB + 5));
    check("R6 one-edge lag", 32'(irq), 32'h0);
    check_stat("R2 status bit", 2);
    tick();
    check("R6 default dest 0", 32'(irq), 32'h1);
    clear(2, 16'h0020);
    tick();
    check_irq("R3 cleared output");
  endtask

  task automatic t_route_prog();
    logic [31:0] d;
    wr(base_of(1), 32'h7654_3210);
    wr(base_of(1) + 12'h4, 32'h0123_4567);
    for (int j = 0; j < 8; j++) begin
      m_code[BB + j]     = 4'(j);
      m_code[BB + 8 + j] = 4'(7 - j);
    end
    rd(base_of(1), d);        check("R5 readback lo", d, 32'h7654_3210);
    rd(base_of(1) + 12'h4, d); check("R5 readback hi", d, 32'h0123_4567);
    pulse(NC'(1) << (BB + 3));
    tick();
    check("R5 lo field dest 3", 32'(irq), 32'h08);
    pulse(NC'(1) << (BB + 9));
    tick();
    check("R5 hi field dest 6", 32'(irq), 32'h48);
    clear(1, 16'hFFFF);
    tick();
    check_irq("R3 bank1 cleared");
  endtask

  task automatic t_clear();
    logic [31:0] d;
    pulse(NC'(16'h00F0));
    tick();
    check_irq("R6 bank0 pending");
    clear(0, 16'h0000);
    check_stat("R3 zero write no effect", 0);
    clear(0, 16'h0030);
    check_stat("R3 partial clear", 0);
    rd(base_of(0) + 12'h8, d);
    check("R3 clear reads zero", d, 32'h0);
    clear(0, 16'h00C0);
    tick();
    check("R3 all cleared", 32'(irq), 32'h0);
  endtask

  task automatic t_collision();
    pulse(NC'(16'h0300) << (3*BB));
    evt = NC'(16'h0200) << (3*BB);
    addr = base_of(3) + 12'h8; wdata = 32'h0000_0300; we = 1'b1;
    tick();
    we = 1'b0; evt = '0;
    m_pend[3*BB +: BB] = (m_pend[3*BB +: BB] & ~16'h0300) | 16'h0200;
    check_stat("R4 event wins", 3);
    tick();
    check_irq("R4 output kept");
    clear(3, 16'hFFFF);
  endtask

  task automatic t_disable();
    int c = 3*BB + 2;
    set_code(c, 4'hF);
    pulse(NC'(1) << c);
    tick();
    check("R7 disabled no output", 32'(irq), 32'h0);
    check_stat("R7 still pending", 3);
    set_code(c, 4'h4);
    tick();
    check("R6 reroute pending", 32'(irq), 32'h10);
    clear(3, 16'hFFFF);
    set_code(c, 4'h0);
    tick();
  endtask

  task automatic t_reserved();
    for (int v = 8; v < 15; v++) begin
      set_code(0, 4'(v));
      pulse(NC'(1));
      tick();
      check($sformatf("R8 reserved code %0d", v), 32'(irq), 32'h0);
      clear(0, 16'h0001);
    end
    set_code(0, 4'h0);
  endtask

  task automatic t_share();
    set_code(5, 4'h6);
    set_code(40, 4'h6);
    pulse((NC'(1) << 5) | (NC'(1) << 40));
    tick();
    check("R9 shared high", 32'(irq), 32'h40);
    clear(0, 16'h0020);
    tick();
    check("R9 one left", 32'(irq), 32'h40);
    clear(2, 16'h0100);
    tick();
    check("R9 both cleared", 32'(irq), 32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    pulse(NC'(1) << (BB + 4));
    wr(base_of(1) + 12'hC, 32'h0);
    wr(base_of(1) + 12'hC, 32'hFFFF_FFFF);
    check_stat("R10 status write ignored", 1);
    wr(12'h2C0, 32'hFFFF_FFFF);
    wr(12'h27C, 32'hFFFF_FFFF);
    wr(12'h282, 32'hFFFF_FFFF);
    rd(base_of(0), d);
    check("R10 routing untouched", d, {m_code[7], m_code[6], m_code[5], m_code[4],
                                       m_code[3], m_code[2], m_code[1], m_code[0]});
    tick();
    check_irq("R10 output unchanged");
    rd(12'h2C0, d); check("R10 unmapped high", d, 32'h0);
    rd(12'h27C, d); check("R10 unmapped low", d, 32'h0);
    rd(12'h28E, d); check("R10 misaligned", d, 32'h0);
    clear(1, 16'hFFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) m_code[i] = 4'h0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_default_route();
    t_route_prog();
    t_clear();
    t_collision();
    t_disable();
    t_reserved();
    t_share();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule